// File: doc/BRIEF.md
# Bubble-Tolerant Thermometer-to-Binary Encoder

This block sits behind a bank of seven flash comparators and turns their outputs into a 3-bit binary code. Each comparator line is active low. A line drops to 0 once the analog input rises above that line's reference. As the input grows, more lines go low, starting from line 0.

Inside the block the lines are inverted. The inverted vector gets a fixed 1 below line 0 and a fixed 0 above line 6. A 3-input window gate at every line position looks for the point where ones turn into zeros. The window accepts an edge only if the line and the line below it are both asserted and the line above is not. Because of this, an isolated asserted line standing among unasserted ones produces no edge. Each edge found is turned into its binary code. If more than one edge appears, their codes are ORed together.

The result is captured into an output register only on cycles where the sample enable is high. Uneven settling of the combinational path therefore never shows at the output. A valid flag marks each capture.

Top module: `therm_bubble_enc`

## Requirements
- R1: With all seven comparator lines high (none asserted), a sample yields code 0.
- R2: A clean pattern, where lines 0 to k-1 are low and the rest high (k from 0 to 7), yields code k on the sample.
- R3: One asserted (low) line that has an unasserted (high) line on each side, and lies above the lowest boundary, leaves the code equal to the count of the low run starting at line 0.
- R4: Each position i (bit i of the line vector, bit 0 = line 0) at which line i and line i-1 are low and line i+1 is high contributes the value i+1. When several such positions exist, the code is the bitwise OR of their values. No error is flagged.
- R5: For the window gates, line 0 has an always-asserted line below it and line 6 has a never-asserted line above it. So line 0 low with line 1 high gives code 1, and all lines low gives code 7.
- R6: The code output changes only on the clock edge that follows a cycle with sample enable high. Input changes on other cycles leave it unchanged.
- R7: Valid is high for exactly the cycle after each cycle with sample enable high, and low otherwise.
- R8: A synchronous reset clears the code to 0 and valid to 0, and it wins over a sample enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sample_en_i | input | 1 | Capture the encoded value on this edge |
| cmp_n_i | input | 7 | Comparator lines, active low, bit 0 = lowest reference |
| code_o | output | 3 | Registered binary code |
| valid_o | output | 1 | One-cycle flag after each capture |

## Verification
Reset and sample enable can both be active in the same cycle. The bench raises both on one edge while it presents a pattern that would otherwise encode to a nonzero code. It then expects code 0 with valid low, which shows that reset takes priority. Capture and hold can also meet across back-to-back edges. The bench samples on two consecutive cycles, then changes the lines with the enable low. Valid must stay high for both captured cycles. The code must follow each capture and then stay frozen while the lines change.

// File: rtl/tenc_pkg.sv
package tenc_pkg;

    // Default output code width; the line count follows from it.
    localparam int unsigned CODE_W_DEF = 3;

    // True when v is a clean run of ones starting at bit 0 (including zero).
    function automatic logic thermo_ok(input logic [63:0] v);
        return ((v & (v + 64'd1)) == 64'd0);
    endfunction

endpackage

// File: rtl/tenc_front.sv
module tenc_front #(
    parameter int unsigned LINES = 7
) (
    input  logic [LINES-1:0] cmp_n_i,
    output logic [LINES+1:0] t_pad_o
);
    // Bit 0: virtual line below the lowest one (always asserted).
    // Bits 1..LINES: inverted comparator lines.
    // Bit LINES+1: virtual line above the top one (never asserted).
    assign t_pad_o = {1'b0, ~cmp_n_i, 1'b1};
endmodule

// File: rtl/tenc_window.sv
module tenc_window #(
    parameter int unsigned LINES = 7
) (
    input  logic [LINES+1:0] t_pad_i,
    output logic [LINES-1:0] hot_o
);
    import tenc_pkg::*;

    for (genvar i = 0; i < LINES; i++) begin : g_win
        // Position i is an edge when it and the one below are asserted
        // and the one above is not.
        assign hot_o[i] = t_pad_i[i+1] & t_pad_i[i] & ~t_pad_i[i+2];
    end

    logic [LINES-1:0] t_mid;
    assign t_mid = t_pad_i[LINES:1];

    // A clean run can have at most one edge (R2).
    always_comb begin
        if (thermo_ok(64'(t_mid))) begin
            assert_single_edge_R2: assert ($onehot0(hot_o));
        end
    end
endmodule

// File: rtl/tenc_encoder.sv
module tenc_encoder #(
    parameter int unsigned LINES  = 7,
    parameter int unsigned CODE_W = 3
) (
    input  logic [LINES-1:0]  hot_i,
    output logic [CODE_W-1:0] code_o
);
    // Wired-OR encoding: every active edge adds its position plus one.
    always_comb begin
        code_o = '0;
        for (int i = 0; i < LINES; i++) begin
            if (hot_i[i]) code_o = code_o | CODE_W'(i + 1);
        end
    end

    always_comb begin
        if (hot_i == '0) begin
            assert_no_edge_zero_R1: assert (code_o == '0);
        end
    end
endmodule

// File: rtl/therm_bubble_enc.sv
module therm_bubble_enc #(
    parameter int unsigned CODE_W = tenc_pkg::CODE_W_DEF
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        sample_en_i,
    input  logic [(2**CODE_W)-2:0]      cmp_n_i,
    output logic [CODE_W-1:0]           code_o,
    output logic                        valid_o
);
    import tenc_pkg::*;

    localparam int unsigned LINES = (2 ** CODE_W) - 1;

    logic [LINES+1:0]  t_pad;
    logic [LINES-1:0]  hot;
    logic [CODE_W-1:0] enc_code;
    logic [LINES-1:0]  t_raw;

    tenc_front #(.LINES(LINES)) u_front (
        .cmp_n_i (cmp_n_i),
        .t_pad_o (t_pad)
    );

    tenc_window #(.LINES(LINES)) u_window (
        .t_pad_i (t_pad),
        .hot_o   (hot)
    );

    tenc_encoder #(.LINES(LINES), .CODE_W(CODE_W)) u_enc (
        .hot_i  (hot),
        .code_o (enc_code)
    );

    // Output register: only settled values reach the pins.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            code_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= sample_en_i;
            if (sample_en_i) code_o <= enc_code;
        end
    end

    assign t_raw = ~cmp_n_i;

    assert_clean_count_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (sample_en_i && thermo_ok(64'(t_raw))) |=>
        (code_o == CODE_W'($countones($past(t_raw)))));

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !sample_en_i |=> $stable(code_o));

    assert_valid_set_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        sample_en_i |=> valid_o);

    assert_valid_clr_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !sample_en_i |=> !valid_o);

    assert_reset_R8: assert property (@(posedge clk_i)
        rst_i |=> (code_o == '0 && !valid_o));
endmodule

// File: tb/tb_therm_bubble_enc.sv
`timescale 1ns/1ps
module tb_therm_bubble_enc;

    logic       clk = 1'b0;
    logic       rst;
    logic       sample_en;
    logic [6:0] cmp_n;
    logic [2:0] code;
    logic       valid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    therm_bubble_enc dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .sample_en_i (sample_en),
        .cmp_n_i     (cmp_n),
        .code_o      (code),
        .valid_o     (valid)
    );

    // {requirement id, comparator lines (active low), expected code}
    localparam int NV = 16;
    localparam logic [13:0] VEC [NV] = '{
        {4'd1, 7'h7F, 3'd0},
        {4'd2, 7'h7E, 3'd1},
        {4'd2, 7'h7C, 3'd2},
        {4'd2, 7'h78, 3'd3},
        {4'd2, 7'h70, 3'd4},
        {4'd2, 7'h60, 3'd5},
        {4'd2, 7'h40, 3'd6},
        {4'd5, 7'h00, 3'd7},
        {4'd3, 7'h74, 3'd2},
        {4'd3, 7'h58, 3'd3},
        {4'd3, 7'h30, 3'd4},
        {4'd4, 7'h6F, 3'd0},
        {4'd4, 7'h64, 3'd7},
        {4'd4, 7'h10, 3'd7},
        {4'd4, 7'h4C, 3'd6},
        {4'd5, 7'h7A, 3'd1}
    };

    function automatic string rname(input int id);
        case (id)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input logic [2:0] c_exp, input logic v_exp);
        checks++;
        if (code !== c_exp || valid !== v_exp) begin
            errors++;
            $display("FAIL %s code=%0d valid=%0b expected code=%0d valid=%0b",
                     req, code, valid, c_exp, v_exp);
        end
    endtask

    // Drive on a falling edge, let one rising edge pass, return at next falling edge.
    task automatic step(input logic [6:0] lines, input logic en, input logic r);
        @(negedge clk);
        cmp_n     = lines;
        sample_en = en;
        rst       = r;
        @(negedge clk);
        sample_en = 1'b0;
        rst       = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; sample_en = 1'b0; cmp_n = 7'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R8", 3'd0, 1'b0);               // reset state

        // Table walk: each vector captured, valid pulse checked (R7)
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][9:3], 1'b1, 1'b0);
            chk(rname(int'(VEC[i][13:10])), VEC[i][2:0], 1'b1);
        end

        // R6 and R7: input change without enable, code holds, valid drops
        step(7'h70, 1'b1, 1'b0);
        chk("R6", 3'd4, 1'b1);
        step(7'h00, 1'b0, 1'b0);
        chk("R6", 3'd4, 1'b0);
        step(7'h7E, 1'b0, 1'b0);
        chk("R7", 3'd4, 1'b0);

        // Back-to-back captures: valid stays high, code follows (R7)
        @(negedge clk);
        cmp_n = 7'h78; sample_en = 1'b1;
        @(negedge clk);
        chk("R7", 3'd3, 1'b1);
        cmp_n = 7'h40;
        @(negedge clk);
        sample_en = 1'b0;
        chk("R7", 3'd6, 1'b1);
        cmp_n = 7'h7F;
        @(negedge clk);
        chk("R6", 3'd6, 1'b0);

        // Reset and sample in the same cycle: reset wins (R8)
        step(7'h00, 1'b1, 1'b1);
        chk("R8", 3'd0, 1'b0);

        // Capture works again after reset (R2)
        step(7'h60, 1'b1, 1'b0);
        chk("R2", 3'd5, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule